// File: doc/BRIEF.md
# Arithmetic Fat-Tree Route Unit

This block picks the output port of a fat-tree router for each new packet without any lookup table. End-point addresses are geographic: each level of the machine hierarchy owns a fixed slice of the 24-bit destination field. The output port therefore follows from a few comparisons and additions on those slices, the router's own position in the tree, and a small set of static port bases.

A router at the top of the tree always sends traffic downward, toward the destination cabinet. A router one tier lower sends traffic down toward the destination chassis when the packet is bound for its own cabinet. Otherwise it sends the packet up one of its uplinks. The uplinks are taken in rotation, so load spreads across the parallel paths.

The unit sees the header flit once, on a strobe, and returns a registered decision one cycle later. That decision stays on the outputs, and the rest of the packet's flits follow it until the next header arrives.

Top module: `geo_route_unit`

## Requirements
- R1: The destination field `hdr_dest` is decoded with these bit positions: bits [1:0] chip, bits [5:2] board, bits [9:6] mezzanine, bits [13:10] chassis, bits [21:14] cabinet, and bits [23:22] spare.
- R2: When `cfg_top_tier` is 1, the routed port is `(cfg_cabinet_base + cabinet) mod NUM_PORTS` and `route_up` is 0.
- R3: When `cfg_top_tier` is 0 and `cfg_router_id` equals the destination cabinet, the routed port is `(cfg_chassis_base + chassis) mod NUM_PORTS` and `route_up` is 0.
- R4: When `cfg_top_tier` is 0 and `cfg_router_id` differs from the destination cabinet, the routed port is `(cfg_uplink_base + pointer) mod NUM_PORTS` and `route_up` is 1.
- R5: After each upward header, the uplink pointer advances by one. When the advanced value would reach `cfg_uplink_cnt`, the pointer wraps to 0. With a count of 0 or 1, the pointer stays at 0.
- R6: A header routed downward leaves the uplink pointer unchanged.
- R7: The spare bits [23:22] have no effect on the routed port or on `route_up`.
- R8: `route_valid` is high in exactly the cycle after each cycle in which `hdr_valid` is high, and low otherwise. Back-to-back headers give back-to-back decisions.
- R9: `route_port`, `route_onehot` and `route_up` hold the last decision until the next header.
- R10: During reset, `route_valid`, `route_port` and `route_up` are 0. After reset, the first upward header uses uplink pointer 0.
- R11: `route_onehot` has exactly the bit numbered `route_port` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header flit present this cycle |
| hdr_dest | input | 24 | Destination end-point address |
| cfg_top_tier | input | 1 | 1: top-tier router, 0: tier below it |
| cfg_router_id | input | 8 | Cabinet number this router serves |
| cfg_chassis_base | input | PORT_W | First port of the chassis-facing downlinks |
| cfg_cabinet_base | input | PORT_W | First port of the cabinet-facing downlinks |
| cfg_uplink_base | input | PORT_W | First uplink port |
| cfg_uplink_cnt | input | PORT_W+1 | Number of uplinks |
| route_valid | output | 1 | Decision valid (one-cycle pulse) |
| route_port | output | PORT_W | Encoded output port |
| route_onehot | output | NUM_PORTS | One-hot output port |
| route_up | output | 1 | Decision went to an uplink |

## Verification
Every decision is due one rising edge after its header strobe. The bench drives a header on a falling edge and reads the outputs at the next falling edge, which lies after exactly one register stage. One falling edge later it checks that the valid pulse has ended and that the decision is still held. The effect of the pointer on a header shows up only in the next upward decision, so the bench keeps its own rotation count and compares it against each uplink port it sees. The effect of a reset is checked through the first upward decision after it.

// File: rtl/geo_route_pkg.sv
package geo_route_pkg;
  localparam int DEST_W    = 24;
  localparam int CAB_W     = 8;
  localparam int CHASSIS_W = 4;

  typedef struct packed {
    logic [1:0]           spare;
    logic [CAB_W-1:0]     cabinet;
    logic [CHASSIS_W-1:0] chassis;
    logic [3:0]           mezz;
    logic [3:0]           board;
    logic [1:0]           chip;
  } geo_dest_t;
endpackage

// File: rtl/geo_addr_decode.sv
module geo_addr_decode
  import geo_route_pkg::*;
(
  input  logic [DEST_W-1:0]    dest,
  output logic [CAB_W-1:0]     cabinet,
  output logic [CHASSIS_W-1:0] chassis
);
  geo_dest_t fields;

  // R1: field layout comes from the packed struct; spare bits go nowhere (R7)
  always_comb begin
    fields  = geo_dest_t'(dest);
    cabinet = fields.cabinet;
    chassis = fields.chassis;
  end
endmodule

// File: rtl/geo_port_select.sv
module geo_port_select
  import geo_route_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic                 is_top,
  input  logic [CAB_W-1:0]     router_id,
  input  logic [CAB_W-1:0]     cabinet,
  input  logic [CHASSIS_W-1:0] chassis,
  input  logic [PORT_W-1:0]    chassis_base,
  input  logic [PORT_W-1:0]    cabinet_base,
  input  logic [PORT_W-1:0]    uplink_base,
  input  logic [PORT_W-1:0]    uplink_ptr,
  output logic [PORT_W-1:0]    port,
  output logic                 go_up
);
  localparam int SUM_W = (PORT_W > CAB_W) ? PORT_W : CAB_W;

  function automatic logic [PORT_W-1:0] wrap_add(
    input logic [PORT_W-1:0] base,
    input logic [SUM_W-1:0]  off
  );
    logic [SUM_W-1:0] s;
    s = SUM_W'(base) + off;
    return s[PORT_W-1:0];
  endfunction

  always_comb begin
    go_up = 1'b0;
    if (is_top) begin
      port = wrap_add(cabinet_base, SUM_W'(cabinet));
    end else if (router_id == cabinet) begin
      port = wrap_add(chassis_base, SUM_W'(chassis));
    end else begin
      port  = wrap_add(uplink_base, SUM_W'(uplink_ptr));
      go_up = 1'b1;
    end
  end
endmodule

// File: rtl/geo_uplink_rr.sv
module geo_uplink_rr #(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [PORT_W:0]   uplink_cnt,
  output logic [PORT_W-1:0] ptr
);
  logic [PORT_W:0] bumped;

  always_comb bumped = {1'b0, ptr} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (advance) begin
      ptr <= (bumped >= uplink_cnt) ? '0 : bumped[PORT_W-1:0];
    end
  end
endmodule

// File: rtl/geo_route_unit.sv
module geo_route_unit
  import geo_route_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hdr_valid,
  input  logic [DEST_W-1:0]    hdr_dest,
  input  logic                 cfg_top_tier,
  input  logic [CAB_W-1:0]     cfg_router_id,
  input  logic [PORT_W-1:0]    cfg_chassis_base,
  input  logic [PORT_W-1:0]    cfg_cabinet_base,
  input  logic [PORT_W-1:0]    cfg_uplink_base,
  input  logic [PORT_W:0]      cfg_uplink_cnt,
  output logic                 route_valid,
  output logic [PORT_W-1:0]    route_port,
  output logic [NUM_PORTS-1:0] route_onehot,
  output logic                 route_up
);
  logic [CAB_W-1:0]     dest_cab;
  logic [CHASSIS_W-1:0] dest_chassis;
  logic [PORT_W-1:0]    upl_ptr;
  logic [PORT_W-1:0]    next_port;
  logic                 next_up;
  logic                 take_up;

  function automatic logic [NUM_PORTS-1:0] to_onehot(input logic [PORT_W-1:0] p);
    logic [NUM_PORTS-1:0] v;
    v = '0;
    v[p] = 1'b1;
    return v;
  endfunction

  geo_addr_decode u_dec (
    .dest    (hdr_dest),
    .cabinet (dest_cab),
    .chassis (dest_chassis)
  );

  geo_port_select #(.PORT_W(PORT_W)) u_sel (
    .is_top       (cfg_top_tier),
    .router_id    (cfg_router_id),
    .cabinet      (dest_cab),
    .chassis      (dest_chassis),
    .chassis_base (cfg_chassis_base),
    .cabinet_base (cfg_cabinet_base),
    .uplink_base  (cfg_uplink_base),
    .uplink_ptr   (upl_ptr),
    .port         (next_port),
    .go_up        (next_up)
  );

  // the pointer moves only on an upward header (R5, R6)
  always_comb take_up = hdr_valid && next_up;

  geo_uplink_rr #(.PORT_W(PORT_W)) u_rr (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (take_up),
    .uplink_cnt (cfg_uplink_cnt),
    .ptr        (upl_ptr)
  );

  // single register stage: decision captured once per header, then held (R8, R9)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_valid  <= 1'b0;
      route_port   <= '0;
      route_onehot <= to_onehot('0);
      route_up     <= 1'b0;
    end else begin
      route_valid <= hdr_valid;
      if (hdr_valid) begin
        route_port   <= next_port;
        route_onehot <= to_onehot(next_port);
        route_up     <= next_up;
      end
    end
  end
endmodule

// File: rtl/geo_route_chk.sv
module geo_route_chk #(
  parameter int NUM_PORTS = 16,
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hdr_valid,
  input logic                 cfg_top_tier,
  input logic                 route_valid,
  input logic [PORT_W-1:0]    route_port,
  input logic [NUM_PORTS-1:0] route_onehot,
  input logic                 route_up,
  input logic [PORT_W-1:0]    upl_ptr,
  input logic                 take_up
);
  // R8
  valid_follows_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> route_valid);

  // R8
  valid_only_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !route_valid);

  // R11
  onehot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(route_onehot) == 1);

  // R9
  decision_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> ($stable(route_port) && $stable(route_up) && $stable(route_onehot)));

  // R6
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_up |=> $stable(upl_ptr));

  // R2
  top_never_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && cfg_top_tier) |=> !route_up);
endmodule

bind geo_route_unit geo_route_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hdr_valid    (hdr_valid),
  .cfg_top_tier (cfg_top_tier),
  .route_valid  (route_valid),
  .route_port   (route_port),
  .route_onehot (route_onehot),
  .route_up     (route_up),
  .upl_ptr      (upl_ptr),
  .take_up      (take_up)
);

// File: tb/geo_route_unit_bench.sv
`timescale 1ns/1ps
module geo_route_unit_bench;
  localparam int NP = 16;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hdr_valid = 1'b0;
  logic [23:0]   hdr_dest = '0;
  logic          cfg_top_tier = 1'b0;
  logic [7:0]    cfg_router_id = '0;
  logic [PW-1:0] cfg_chassis_base = '0;
  logic [PW-1:0] cfg_cabinet_base = '0;
  logic [PW-1:0] cfg_uplink_base = '0;
  logic [PW:0]   cfg_uplink_cnt = '0;
  logic          route_valid;
  logic [PW-1:0] route_port;
  logic [NP-1:0] route_onehot;
  logic          route_up;

  int checks = 0;
  int fails  = 0;
  int mptr   = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  geo_route_unit #(.NUM_PORTS(NP)) u_geo_route_unit (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_dest(hdr_dest),
    .cfg_top_tier(cfg_top_tier), .cfg_router_id(cfg_router_id),
    .cfg_chassis_base(cfg_chassis_base), .cfg_cabinet_base(cfg_cabinet_base),
    .cfg_uplink_base(cfg_uplink_base), .cfg_uplink_cnt(cfg_uplink_cnt),
    .route_valid(route_valid), .route_port(route_port),
    .route_onehot(route_onehot), .route_up(route_up)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input int cab, input int chs, input int spare, input int low);
    return {2'(spare), 8'(cab), 4'(chs), 10'(low)};
  endfunction

  // Drive one header; outputs are checked one edge later.
  task automatic send(input logic [23:0] d, input int exp_port, input int exp_up, input string req);
    hdr_valid = 1'b1;
    hdr_dest  = d;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk({req, " R8 valid"}, route_valid, 1);
    chk({req, " port"}, route_port, exp_port);
    chk({req, " up"}, route_up, exp_up);
    chk("R11 onehot", route_onehot, 1 << exp_port);
  endtask

  task automatic up_exp(output int p);
    p = (cfg_uplink_base + mptr) % NP;
    mptr = (mptr + 1 >= cfg_uplink_cnt) ? 0 : mptr + 1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 valid in reset", route_valid, 0);
    chk("R10 port in reset", route_port, 0);
    chk("R10 up in reset", route_up, 0);
    rst_n = 1'b1;
    mptr = 0;
    @(negedge clk);
  endtask

  initial begin
    int p;
    @(negedge clk);
    do_reset();

    // R2 sweep: top tier, every cabinet, spare bits varied
    cfg_top_tier = 1'b1;
    cfg_cabinet_base = 4'd3;
    for (int c = 0; c < 256; c++)
      send(mk(c, c % 16, c % 4, c * 7), (3 + c) % NP, 0, "R2");

    // R8 pulse ends, R9 hold
    @(negedge clk);
    chk("R8 pulse ends", route_valid, 0);
    chk("R9 port held", route_port, (3 + 255) % NP);

    // R3/R4/R5/R6 sweep: tier below top, id 5, 3 uplinks from port 12
    cfg_top_tier = 1'b0;
    cfg_router_id = 8'd5;
    cfg_chassis_base = 4'd1;
    cfg_uplink_base = 4'd12;
    cfg_uplink_cnt = 5'd3;
    do_reset();
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 16; s++) begin
        if (c == 5) send(mk(c, s, 0, s), (1 + s) % NP, 0, "R3/R6");
        else begin
          up_exp(p);
          send(mk(c, s, 0, s), p, 1, "R4/R5");
        end
      end

    // R7: spare bits do not change the result (local, then remote)
    for (int sp = 0; sp < 4; sp++) begin
      send(mk(5, 9, sp, 0), 10, 0, "R7 local");
      up_exp(p);
      send(mk(200, 9, sp, 0), p, 1, "R7 remote");
    end

    // R5: four uplinks wrapping at port 15 -> 0
    cfg_uplink_cnt = 5'd4;
    cfg_uplink_base = 4'd14;
    do_reset();
    for (int i = 0; i < 10; i++) begin
      up_exp(p);
      send(mk(6, 0, 0, 0), p, 1, "R5 wrap");
    end

    // R10: reset mid-rotation returns to first uplink
    do_reset();
    send(mk(7, 0, 0, 0), 14, 1, "R10 first uplink");

    // R5: count 1 and count 0 keep pointer at 0
    cfg_uplink_cnt = 5'd1;
    do_reset();
    for (int i = 0; i < 3; i++) send(mk(9, 0, 0, 0), 14, 1, "R5 cnt1");
    cfg_uplink_cnt = 5'd0;
    do_reset();
    for (int i = 0; i < 3; i++) send(mk(9, 0, 0, 0), 14, 1, "R5 cnt0");

    // R6: downward headers between upward ones leave rotation alone
    cfg_uplink_cnt = 5'd3;
    cfg_uplink_base = 4'd8;
    do_reset();
    send(mk(1, 0, 0, 0), 8, 0 + 1, "R4");
    send(mk(5, 2, 0, 0), 3, 0, "R6 down");
    send(mk(5, 3, 0, 0), 4, 0, "R6 down");
    send(mk(1, 0, 0, 0), 9, 1, "R6 pointer kept");
    @(negedge clk);
    chk("R9 up held", route_up, 1);
    chk("R8 idle", route_valid, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule